// File: doc/BRIEF.md
# Windowed Page Mapper for a 16-bit Bus

This block sits between a 16-bit-address CPU bus and a paged RAM of up to 1 MB. The logical address space is split into sixteen 4 KB windows, and each window owns an 8-bit page register. For a RAM window, the physical address is formed from that register and the untouched 12-bit offset. The translation is purely combinational. An access to a mapped window therefore reaches the RAM in the same cycle as an access to fixed RAM, and no wait state is inserted.

Software controls the block through a single-bit I/O space. The bit at the control base opens the page registers on the memory bus. The next bit switches between pass-through and mapped translation. A bit in a second I/O block lets RAM answer in the two windows that peripheral ROMs normally occupy. Software must clear that bit before it calls a peripheral ROM. The ROM windows, the console I/O windows and the cartridge window are never given a RAM chip-select. This leaves the cartridge area as a stable place for the code that changes the mapping.

When register access is open, register n sits at word address `REG_BASE + 2n`. A write latches the high data byte into the register, and a read returns the stored page in the high byte.

Top module: `mem_page_mapper`

## Requirements
- R1: After reset, register access, mapped mode and the optional window are all off. Every page register holds its own window index, so register 5 reads back as 0x0500.
- R2: A set strobe on I/O address `CTRL_BASE + 2n` sets control bit n, and a clear strobe on that address clears it. Bit 0 is register access and bit 1 is mapped mode. When set and clear arrive in the same cycle, the clear takes effect. A test strobe returns the addressed bit on `io_tbit`.
- R3: While register access is on, a write to `REG_BASE + 2n` (n = address bits [4:1]) latches data bits [15:8] into register n at the next clock edge, and data bits [7:0] are ignored. While register access is off, such writes leave every register unchanged.
- R4: While register access is on, a read in the register range drives `{page, 8'h00}` on `cpu_rdata` with `cpu_rdata_oe` high and the RAM chip-select low. While register access is off, `cpu_rdata_oe` stays low.
- R5: In mapped mode, `phys_addr` = {register[addr[15:12]], addr[11:0]}.
- R6: In pass-through mode, `phys_addr` = {4'h0, addr}, whatever the registers hold.
- R7: `ram_cs` is high only during a read or write to windows 2, 3 or 10 to 15. It is never high for windows 0, 1, 6, 7, 8 or 9.
- R8: Windows 4 and 5 get `ram_cs` only while the optional-window bit (bit 5 at I/O base 0x5FC0, address 0x5FCA) is set. The register range takes precedence over the optional window.
- R9: Translation and chip-select are valid in the same cycle in which the address and strobe are presented, with no added latency.
- R10: A register written at a clock edge is used by the translation for every access that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Logical byte address |
| cpu_wdata | input | 16 | Write data; high byte carries a page number |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| io_addr | input | 16 | Single-bit I/O address (bit n at base + 2n) |
| io_set | input | 1 | Set the addressed control bit |
| io_clr | input | 1 | Clear the addressed control bit |
| io_test | input | 1 | Test the addressed control bit |
| io_tbit | output | 1 | Value of the tested bit |
| cpu_rdata | output | 16 | Page register read data |
| cpu_rdata_oe | output | 1 | Mapper drives the read data |
| ram_cs | output | 1 | Chip-select for the paged RAM |
| phys_addr | output | 20 | Extended physical address |

## Verification
The bench builds the block with its default parameters. These are a 16-bit address, 4 KB windows, 8-bit pages, registers at 0x4000, the control base at 0x1E00 and the optional-window bit at 0x5FCA. With these values all sixteen registers, every window class and both translation modes are reachable in a few hundred cycles. A vector table covers the paged, fixed and optional windows in mapped mode. Directed steps cover the reset identity, writes made while register access is off, the precedence of the register range over the optional window, and a clear arriving together with a set.

// File: rtl/mpm_pkg.sv
`timescale 1ns/1ps
package mpm_pkg;

    // Control state held by the single-bit I/O block
    typedef struct packed {
        logic reg_en;   // page registers visible on the memory bus
        logic map_en;   // translation applied (else pass-through)
        logic opt_en;   // RAM allowed in the optional windows
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{reg_en: 1'b0, map_en: 1'b0, opt_en: 1'b0};

endpackage

// File: rtl/mpm_ctrl_bits.sv
`timescale 1ns/1ps
module mpm_ctrl_bits #(
    parameter int              ADDR_W    = 16,
    parameter logic [15:0]     CTRL_BASE = 16'h1E00,
    parameter int              REG_BIT   = 0,
    parameter int              MAP_BIT   = 1,
    parameter logic [15:0]     OPT_BASE  = 16'h5FC0,
    parameter int              OPT_BIT   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_set,
    input  logic               io_clr,
    input  logic               io_test,
    output logic               io_tbit,
    output mpm_pkg::ctrl_t     ctrl
);
    import mpm_pkg::*;

    localparam logic [ADDR_W-1:0] REG_ADR = ADDR_W'(32'(CTRL_BASE) + 2 * REG_BIT);
    localparam logic [ADDR_W-1:0] MAP_ADR = ADDR_W'(32'(CTRL_BASE) + 2 * MAP_BIT);
    localparam logic [ADDR_W-1:0] OPT_ADR = ADDR_W'(32'(OPT_BASE)  + 2 * OPT_BIT);

    ctrl_t ctrl_d, ctrl_q;
    logic  hit_reg, hit_map, hit_opt;

    always_comb begin
        hit_reg = (io_addr == REG_ADR);
        hit_map = (io_addr == MAP_ADR);
        hit_opt = (io_addr == OPT_ADR);

        ctrl_d = ctrl_q;
        // set first, clear second: clear wins on a collision
        if (io_set) begin
            if (hit_reg) ctrl_d.reg_en = 1'b1;
            if (hit_map) ctrl_d.map_en = 1'b1;
            if (hit_opt) ctrl_d.opt_en = 1'b1;
        end
        if (io_clr) begin
            if (hit_reg) ctrl_d.reg_en = 1'b0;
            if (hit_map) ctrl_d.map_en = 1'b0;
            if (hit_opt) ctrl_d.opt_en = 1'b0;
        end

        io_tbit = io_test & ((hit_reg & ctrl_q.reg_en) |
                             (hit_map & ctrl_q.map_en) |
                             (hit_opt & ctrl_q.opt_en));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/mpm_page_file.sv
`timescale 1ns/1ps
module mpm_page_file #(
    parameter int NWIN   = 16,
    parameter int PAGE_W = 8,
    localparam int IDX_W = $clog2(NWIN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [PAGE_W-1:0]        wr_page,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [PAGE_W-1:0]        rd_page,
    input  logic [IDX_W-1:0]         xl_idx,
    output logic [PAGE_W-1:0]        xl_page,
    output logic [NWIN*PAGE_W-1:0]   pages_flat
);
    logic [PAGE_W-1:0] pages_d [NWIN];
    logic [PAGE_W-1:0] pages_q [NWIN];

    always_comb begin
        for (int i = 0; i < NWIN; i++) pages_d[i] = pages_q[i];
        if (wr_en) pages_d[wr_idx] = wr_page;
    end

    // Identity mapping at reset: window i points at page i
    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_page
            always_ff @(posedge clk) begin
                if (!rst_n) pages_q[g] <= PAGE_W'(g);
                else        pages_q[g] <= pages_d[g];
            end
            assign pages_flat[g*PAGE_W +: PAGE_W] = pages_q[g];
        end
    endgenerate

    assign rd_page = pages_q[rd_idx];
    assign xl_page = pages_q[xl_idx];

endmodule

// File: rtl/mpm_xlate.sv
`timescale 1ns/1ps
module mpm_xlate #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 12,
    parameter int PAGE_W = 8,
    localparam int WIN_W  = ADDR_W - OFF_W,
    localparam int NWIN   = 1 << WIN_W,
    localparam int PHYS_W = PAGE_W + OFF_W,
    parameter logic [NWIN-1:0]   PAGED_MASK = 16'hFC0C,
    parameter logic [NWIN-1:0]   OPT_MASK   = 16'h0030,
    parameter logic [ADDR_W-1:0] REG_BASE   = 16'h4000
) (
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  mpm_pkg::ctrl_t     ctrl,
    input  logic [PAGE_W-1:0]  xl_page,
    output logic [WIN_W-1:0]   win_idx,
    output logic               reg_hit,
    output logic               ram_cs,
    output logic [PHYS_W-1:0]  phys_addr
);
    localparam int REG_SPAN = 2 * NWIN;

    logic [31:0] a32;
    logic        win_ok;

    always_comb begin
        a32     = 32'(cpu_addr);
        win_idx = cpu_addr[ADDR_W-1 -: WIN_W];
        reg_hit = ctrl.reg_en &&
                  (a32 >= 32'(REG_BASE)) &&
                  (a32 <  32'(REG_BASE) + 32'(REG_SPAN));
        win_ok  = PAGED_MASK[win_idx] | (OPT_MASK[win_idx] & ctrl.opt_en);
        ram_cs  = (cpu_rd | cpu_wr) & win_ok & ~reg_hit;
        if (ctrl.map_en) phys_addr = {xl_page, cpu_addr[OFF_W-1:0]};
        else             phys_addr = PHYS_W'(cpu_addr);
    end

endmodule

// File: rtl/mem_page_mapper.sv
`timescale 1ns/1ps
module mem_page_mapper #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int OFF_W  = 12,
    parameter int PAGE_W = 8,
    localparam int WIN_W  = ADDR_W - OFF_W,
    localparam int NWIN   = 1 << WIN_W,
    localparam int PHYS_W = PAGE_W + OFF_W,
    parameter logic [NWIN-1:0]   PAGED_MASK = 16'hFC0C,
    parameter logic [NWIN-1:0]   OPT_MASK   = 16'h0030,
    parameter logic [ADDR_W-1:0] REG_BASE   = 16'h4000,
    parameter logic [15:0]       CTRL_BASE  = 16'h1E00,
    parameter logic [15:0]       OPT_BASE   = 16'h5FC0,
    parameter int                OPT_BIT    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_set,
    input  logic               io_clr,
    input  logic               io_test,
    output logic               io_tbit,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_rdata_oe,
    output logic               ram_cs,
    output logic [PHYS_W-1:0]  phys_addr
);
    import mpm_pkg::*;

    ctrl_t                  ctrl;
    logic [WIN_W-1:0]       win_idx;
    logic [WIN_W-1:0]       reg_idx;
    logic                   reg_hit;
    logic [PAGE_W-1:0]      rd_page, xl_page;
    logic [NWIN*PAGE_W-1:0] pages_flat;
    logic                   unused_wdata_lo;

    assign reg_idx         = cpu_addr[WIN_W:1];
    assign unused_wdata_lo = ^cpu_wdata[DATA_W-PAGE_W-1:0];

    mpm_ctrl_bits #(
        .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE), .REG_BIT(0), .MAP_BIT(1),
        .OPT_BASE(OPT_BASE), .OPT_BIT(OPT_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_set(io_set),
        .io_clr(io_clr), .io_test(io_test), .io_tbit(io_tbit), .ctrl(ctrl)
    );

    mpm_page_file #(.NWIN(NWIN), .PAGE_W(PAGE_W)) u_pages (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_hit & cpu_wr), .wr_idx(reg_idx),
        .wr_page(cpu_wdata[DATA_W-1 -: PAGE_W]),
        .rd_idx(reg_idx), .rd_page(rd_page),
        .xl_idx(win_idx), .xl_page(xl_page),
        .pages_flat(pages_flat)
    );

    mpm_xlate #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W),
        .PAGED_MASK(PAGED_MASK), .OPT_MASK(OPT_MASK), .REG_BASE(REG_BASE)
    ) u_xlate (
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ctrl(ctrl),
        .xl_page(xl_page), .win_idx(win_idx), .reg_hit(reg_hit),
        .ram_cs(ram_cs), .phys_addr(phys_addr)
    );

    always_comb begin
        cpu_rdata_oe = reg_hit & cpu_rd;
        cpu_rdata    = cpu_rdata_oe ? {rd_page, {(DATA_W-PAGE_W){1'b0}}} : '0;
    end

endmodule

// File: rtl/mem_page_mapper_chk.sv
`timescale 1ns/1ps
module mem_page_mapper_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 12,
    parameter int PAGE_W = 8,
    localparam int WIN_W  = ADDR_W - OFF_W,
    localparam int NWIN   = 1 << WIN_W,
    localparam int PHYS_W = PAGE_W + OFF_W,
    parameter logic [NWIN-1:0]   PAGED_MASK = 16'hFC0C,
    parameter logic [NWIN-1:0]   OPT_MASK   = 16'h0030,
    parameter logic [15:0]       CTRL_BASE  = 16'h1E00
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        cpu_addr,
    input logic                     cpu_rd,
    input logic [ADDR_W-1:0]        io_addr,
    input logic                     io_clr,
    input logic                     ram_cs,
    input logic [PHYS_W-1:0]        phys_addr,
    input logic                     cpu_rdata_oe,
    input logic                     reg_en,
    input logic                     map_en,
    input logic                     opt_en,
    input logic [NWIN*PAGE_W-1:0]   pages_flat
);
    localparam logic [NWIN-1:0] ALLOW_MASK = PAGED_MASK | OPT_MASK;

    logic [WIN_W-1:0] win;
    assign win = cpu_addr[ADDR_W-1 -: WIN_W];

    a_r7_cs_only_ram_windows: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> ALLOW_MASK[win]);

    a_r8_opt_window_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs && OPT_MASK[win]) |-> opt_en);

    a_r4_reg_read_excludes_ram: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata_oe |-> (!ram_cs && reg_en && cpu_rd));

    a_r6_passthrough_identity: assert property (@(posedge clk) disable iff (!rst_n)
        !map_en |-> (phys_addr == PHYS_W'(cpu_addr)));

    a_r3_locked_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |=> $stable(pages_flat));

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (io_clr && io_addr == ADDR_W'(CTRL_BASE)) |=> !reg_en);

endmodule

bind mem_page_mapper mem_page_mapper_chk #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W),
    .PAGED_MASK(PAGED_MASK), .OPT_MASK(OPT_MASK), .CTRL_BASE(CTRL_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .io_addr(io_addr), .io_clr(io_clr), .ram_cs(ram_cs),
    .phys_addr(phys_addr), .cpu_rdata_oe(cpu_rdata_oe),
    .reg_en(ctrl.reg_en), .map_en(ctrl.map_en), .opt_en(ctrl.opt_en),
    .pages_flat(pages_flat)
);

// File: tb/mem_page_mapper_bench.sv
`timescale 1ns/1ps
module mem_page_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0, io_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic        io_set = 1'b0, io_clr = 1'b0, io_test = 1'b0;
    logic        io_tbit, cpu_rdata_oe, ram_cs;
    logic [15:0] cpu_rdata;
    logic [19:0] phys_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mem_page_mapper u_mem_page_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .io_addr(io_addr), .io_set(io_set),
        .io_clr(io_clr), .io_test(io_test), .io_tbit(io_tbit),
        .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
        .ram_cs(ram_cs), .phys_addr(phys_addr)
    );

    // {rd, wr, addr, expected cs, expected phys}, mapped mode, page i = 0x40+i
    localparam logic [38:0] VEC [12] = '{
        {1'b1, 1'b0, 16'h2345, 1'b1, 20'h42345},
        {1'b0, 1'b1, 16'h3FFE, 1'b1, 20'h43FFE},
        {1'b1, 1'b0, 16'hA000, 1'b1, 20'h4A000},
        {1'b1, 1'b0, 16'hFFFF, 1'b1, 20'h4FFFF},
        {1'b0, 1'b1, 16'hC7A1, 1'b1, 20'h4C7A1},
        {1'b1, 1'b0, 16'h0100, 1'b0, 20'h40100},
        {1'b1, 1'b0, 16'h6000, 1'b0, 20'h46000},
        {1'b0, 1'b1, 16'h7FFF, 1'b0, 20'h47FFF},
        {1'b1, 1'b0, 16'h8300, 1'b0, 20'h48300},
        {1'b1, 1'b0, 16'h4010, 1'b0, 20'h44010},
        {1'b0, 1'b0, 16'hB000, 1'b0, 20'h4B000},
        {1'b1, 1'b0, 16'h9800, 1'b0, 20'h49800}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // present a bus cycle at a falling edge; outputs are sampled 1 ns later
    task automatic bus(input logic rd, input logic wr, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        #1;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic io_op(input logic [15:0] a, input logic s, input logic c);
        @(negedge clk);
        io_addr = a; io_set = s; io_clr = c;
        @(negedge clk);
        io_set = 1'b0; io_clr = 1'b0;
    endtask

    task automatic io_peek(input logic [15:0] a, output logic b);
        @(negedge clk);
        io_addr = a; io_test = 1'b1;
        #1 b = io_tbit;
        io_test = 1'b0;
    endtask

    initial begin
        logic b;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 / R6 / R7 / R9: pass-through after reset, same-cycle chip-select
        bus(1'b1, 1'b0, 16'hA123, 16'h0);
        chk("R1 reset phys", 32'(phys_addr), 32'h0A123);
        chk("R9 cs same cycle", 32'(ram_cs), 32'd1);
        bus_idle();
        io_peek(16'h1E00, b);
        chk("R1 reg access off", 32'(b), 32'd0);
        io_peek(16'h5FCA, b);
        chk("R1 optional off", 32'(b), 32'd0);

        // R2: open register access
        io_op(16'h1E00, 1'b1, 1'b0);
        io_peek(16'h1E00, b);
        chk("R2 set bit0", 32'(b), 32'd1);

        // R1 / R4: identity page read back
        bus(1'b1, 1'b0, 16'h400A, 16'h0);
        chk("R1 identity reg5", 32'(cpu_rdata), 32'h0500);
        chk("R4 oe on reg read", 32'(cpu_rdata_oe), 32'd1);
        chk("R4 cs off on reg read", 32'(ram_cs), 32'd0);

        // R3: program every register, low byte is junk
        for (int i = 0; i < 16; i++)
            bus(1'b0, 1'b1, 16'h4000 + 16'(2 * i), {8'h40 + 8'(i), 8'h5A});
        bus(1'b1, 1'b0, 16'h4006, 16'h0);
        chk("R3 reg3 high byte", 32'(cpu_rdata), 32'h4300);
        bus_idle();

        // R3 / R4: register access closed
        io_op(16'h1E00, 1'b0, 1'b1);
        io_peek(16'h1E00, b);
        chk("R2 clear bit0", 32'(b), 32'd0);
        bus(1'b0, 1'b1, 16'h4004, 16'h9900);
        bus(1'b1, 1'b0, 16'h4004, 16'h0);
        chk("R4 oe off when closed", 32'(cpu_rdata_oe), 32'd0);
        bus_idle();

        // R5 / R7 / R8: table walk in mapped mode
        io_op(16'h1E02, 1'b1, 1'b0);
        io_peek(16'h1E02, b);
        chk("R2 set bit1", 32'(b), 32'd1);
        for (int k = 0; k < 12; k++) begin
            bus(VEC[k][38], VEC[k][37], VEC[k][36:21], 16'h0);
            chk($sformatf("R7 cs vec%0d", k), 32'(ram_cs), 32'(VEC[k][20]));
            chk($sformatf("R5 phys vec%0d", k), 32'(phys_addr), 32'(VEC[k][19:0]));
        end
        bus_idle();

        // R3: write while closed was ignored; R10: new page used next access
        io_op(16'h1E00, 1'b1, 1'b0);
        bus(1'b1, 1'b0, 16'h4004, 16'h0);
        chk("R3 closed write ignored", 32'(cpu_rdata), 32'h4200);
        bus(1'b0, 1'b1, 16'h4014, 16'h7F00);
        bus(1'b1, 1'b0, 16'hA004, 16'h0);
        chk("R10 new page used", 32'(phys_addr), 32'h7F004);

        // R8: optional windows
        io_op(16'h5FCA, 1'b1, 1'b0);
        bus(1'b1, 1'b0, 16'h5000, 16'h0);
        chk("R8 cs optional on", 32'(ram_cs), 32'd1);
        chk("R8 phys optional", 32'(phys_addr), 32'h45000);
        bus(1'b1, 1'b0, 16'h4002, 16'h0);
        chk("R8 reg range wins cs", 32'(ram_cs), 32'd0);
        chk("R4 reg range wins oe", 32'(cpu_rdata_oe), 32'd1);
        bus_idle();
        io_op(16'h5FCA, 1'b0, 1'b1);
        bus(1'b1, 1'b0, 16'h5000, 16'h0);
        chk("R8 cs optional off", 32'(ram_cs), 32'd0);
        bus_idle();

        // R6: pass-through ignores the programmed pages
        io_op(16'h1E02, 1'b0, 1'b1);
        bus(1'b1, 1'b0, 16'hA123, 16'h0);
        chk("R6 passthrough", 32'(phys_addr), 32'h0A123);
        bus_idle();

        // R2: set and clear together, clear wins
        io_op(16'h1E00, 1'b1, 1'b1);
        io_peek(16'h1E00, b);
        chk("R2 clear wins", 32'(b), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule